// File: doc/BRIEF.md
# Gated Sample-Enable Controller

This block sits at the head of a sampled-data processing chain. It decides which clock cycles carry a real sample and makes sure that every later stage sees that decision at the right moment. An active-low enable is sampled on every clock edge. The I and Q input words go into an input register, and a one-bit "sample accepted" flag enters a shift chain with one flop per downstream stage. Each stage therefore gets an enable pulse in exactly the cycle when the sample it must process arrives. Stage k fires once for each accepted sample, k+1 cycles after the capturing edge.

A one-bit mode setting is written through a strobe and picks between two behaviours. In gated mode the chain runs only on accepted samples, which suits input rates below the clock rate. In interpolated mode every clock counts as a sample. When the enable is inactive, zero is written to the input register in place of the data, so the chain sees a zero-stuffed stream at the full clock rate. The arithmetic of the downstream stages is outside this block.

Top module: `sample_gate_ctrl`

## Requirements
- R1: While `rst_n` is sampled low on a rising edge, that edge clears `i_out`, `q_out` and every bit of `stage_en`, and puts the mode back to gated (mode value 0).
- R2: In gated mode, an edge that samples `in_en_n` low loads `i_in` and `q_in` into `i_out` and `q_out`.
- R3: In gated mode, an edge that samples `in_en_n` high leaves `i_out` and `q_out` unchanged, so the data inputs have no effect.
- R4: In gated mode, `stage_en[0]` after an edge equals the inverse of `in_en_n` sampled at that edge.
- R5: For every k from 1 to STAGES-1, `stage_en[k]` after an edge equals `stage_en[k-1]` before it. Each stage therefore pulses once per accepted sample, one cycle after the stage in front of it.
- R6: An edge with `cfg_wr` high stores `cfg_interp` as the mode (1 = interpolated, 0 = gated), and that mode governs the next edge onward. With `cfg_wr` low the mode holds.
- R7: In interpolated mode, an edge that samples `in_en_n` low loads `i_in` and `q_in` into the outputs.
- R8: In interpolated mode, an edge that samples `in_en_n` high loads zero into both `i_out` and `q_out`.
- R9: In interpolated mode, `stage_en[0]` is high after every edge, whatever the value of `in_en_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the mode setting |
| cfg_interp | input | 1 | Mode value written on `cfg_wr`: 1 interpolated, 0 gated |
| in_en_n | input | 1 | Sample enable, active low |
| i_in | input | DATA_W | In-phase input word |
| q_in | input | DATA_W | Quadrature input word |
| i_out | output | DATA_W | Registered in-phase sample |
| q_out | output | DATA_W | Registered quadrature sample |
| stage_en | output | STAGES | Per-stage enable; bit k is the accepted flag delayed by k+1 cycles |

## Verification
The assertions take for granted that every input is a known 0 or 1 at each rising edge, and that reset is held for at least one edge before any check that looks back in time. This matters because the data, hold and zero-stuff properties compare the outputs against the inputs of the previous edge. The bench changes all inputs only on falling clock edges and starts with reset asserted from time zero, so every input value is settled well before the edge that samples it. The stimulus writes the mode while the enable toggles, asserts reset in the middle of interpolated operation, and runs long stretches with the enable held inactive. These cover the transitions into and out of each mode and the draining of the enable chain.

// File: rtl/sgc_pkg.sv
// Package: shared types and helpers for the gated sample-enable controller.
// Assumes: mode encoding 0 = gated, 1 = interpolated.
package sgc_pkg;

    typedef enum logic {
        SGC_GATED  = 1'b0,
        SGC_INTERP = 1'b1
    } sgc_mode_e;

    // Decide whether the current clock carries a sample for the chain.
    function automatic logic sgc_accept(input sgc_mode_e mode, input logic en_n);
        return (mode == SGC_INTERP) ? 1'b1 : ~en_n;
    endfunction

    // Decide whether the input register takes new contents this clock.
    function automatic logic sgc_load(input sgc_mode_e mode, input logic en_n);
        return (mode == SGC_INTERP) | ~en_n;
    endfunction

endpackage

// File: rtl/sgc_mode_reg.sv
// Module: holds the gated/interpolated mode bit.
// Assumes: a write takes effect for the edge after the one that stores it;
// reset returns the block to gated operation.
module sgc_mode_reg
    import sgc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  logic      wr_val,
    output sgc_mode_e mode
);

    sgc_mode_e mode_q;

    // Store the mode on a write strobe, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SGC_GATED;
        end else if (wr) begin
            mode_q <= wr_val ? SGC_INTERP : SGC_GATED;
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/sgc_input_reg.sv
// Module: I/Q input capture register with zero-stuffing.
// Assumes: in gated mode a high enable holds the lanes; in interpolated mode
// a high enable writes zero. One generate lane per component.
module sgc_input_reg
    import sgc_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sgc_mode_e         mode,
    input  logic              en_n,
    input  logic [DATA_W-1:0] i_in,
    input  logic [DATA_W-1:0] q_in,
    output logic [DATA_W-1:0] i_out,
    output logic [DATA_W-1:0] q_out
);

    localparam int LANES = 2;

    logic [LANES-1:0][DATA_W-1:0] lane_in;
    logic [LANES-1:0][DATA_W-1:0] lane_q;
    logic                         load;
    logic                         stuff;

    assign lane_in[0] = i_in;
    assign lane_in[1] = q_in;
    assign load       = sgc_load(mode, en_n);
    assign stuff      = en_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Capture data, write zero or hold, depending on mode and enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (load) begin
                lane_q[g] <= stuff ? '0 : lane_in[g];
            end
        end
    end

    assign i_out = lane_q[0];
    assign q_out = lane_q[1];

endmodule

// File: rtl/sgc_enable_pipe.sv
// Module: shift chain that delays the accepted-sample flag, one flop per
// downstream stage, so that stage k fires k+1 cycles after the capture edge.
// Assumes: STAGES >= 1.
module sgc_enable_pipe #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    output logic [STAGES-1:0] stage_en
);

    logic [STAGES-1:0] en_q;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            // First stage samples the accept flag directly.
            always_ff @(posedge clk) begin
                if (!rst_n) en_q[k] <= 1'b0;
                else        en_q[k] <= accept;
            end
        end else begin : g_tail
            // Later stages copy the stage in front of them.
            always_ff @(posedge clk) begin
                if (!rst_n) en_q[k] <= 1'b0;
                else        en_q[k] <= en_q[k-1];
            end
        end
    end

    assign stage_en = en_q;

endmodule

// File: rtl/sample_gate_ctrl.sv
// Module: top of the gated sample-enable controller.
// Captures I/Q on accepted clocks and hands a delayed enable to each
// downstream stage. Assumes synchronous active-low reset.
module sample_gate_ctrl
    import sgc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_interp,
    input  logic              in_en_n,
    input  logic [DATA_W-1:0] i_in,
    input  logic [DATA_W-1:0] q_in,
    output logic [DATA_W-1:0] i_out,
    output logic [DATA_W-1:0] q_out,
    output logic [STAGES-1:0] stage_en
);

    sgc_mode_e interp_mode;
    logic      accept;

    sgc_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wr_val (cfg_interp),
        .mode   (interp_mode)
    );

    assign accept = sgc_accept(interp_mode, in_en_n);

    sgc_input_reg #(.DATA_W(DATA_W)) u_inreg (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (interp_mode),
        .en_n  (in_en_n),
        .i_in  (i_in),
        .q_in  (q_in),
        .i_out (i_out),
        .q_out (q_out)
    );

    sgc_enable_pipe #(.STAGES(STAGES)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .stage_en (stage_en)
    );

endmodule

// File: rtl/sgc_checker.sv
// Module: property checker for sample_gate_ctrl, attached with bind.
// Assumes: inputs are known at every rising edge; reset is asserted first.
module sgc_checker #(
    parameter int DATA_W = 10,
    parameter int STAGES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              cfg_interp,
    input logic              in_en_n,
    input logic [DATA_W-1:0] i_in,
    input logic [DATA_W-1:0] q_in,
    input logic [DATA_W-1:0] i_out,
    input logic [DATA_W-1:0] q_out,
    input logic [STAGES-1:0] stage_en,
    input logic              mode_bit
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (i_out == '0 && q_out == '0 && stage_en == '0 && !mode_bit));

    assert_gated_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_bit && !in_en_n) |=> (i_out == $past(i_in) && q_out == $past(q_in)));

    assert_gated_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_bit && in_en_n) |=> ($stable(i_out) && $stable(q_out)));

    assert_gated_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bit |=> (stage_en[0] == !$past(in_en_n)));

    for (genvar k = 1; k < STAGES; k++) begin : g_shift
        assert_stage_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (stage_en[k] == $past(stage_en[k-1])));
    end

    assert_mode_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (mode_bit == $past(cfg_interp)));

    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(mode_bit));

    assert_interp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bit && !in_en_n) |=> (i_out == $past(i_in) && q_out == $past(q_in)));

    assert_interp_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bit && in_en_n) |=> (i_out == '0 && q_out == '0));

    assert_interp_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bit |=> stage_en[0]);

endmodule

bind sample_gate_ctrl sgc_checker #(
    .DATA_W (DATA_W),
    .STAGES (STAGES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_interp (cfg_interp),
    .in_en_n    (in_en_n),
    .i_in       (i_in),
    .q_in       (q_in),
    .i_out      (i_out),
    .q_out      (q_out),
    .stage_en   (stage_en),
    .mode_bit   (interp_mode)
);

// File: tb/sample_gate_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on each rising edge, compared
// with every output on each falling edge.
module sample_gate_ctrl_tb;

    localparam int DATA_W = 10;
    localparam int STAGES = 4;
    localparam int MAX_CYCLES = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic              cfg_interp = 1'b0;
    logic              in_en_n = 1'b1;
    logic [DATA_W-1:0] i_in = '0;
    logic [DATA_W-1:0] q_in = '0;
    logic [DATA_W-1:0] i_out;
    logic [DATA_W-1:0] q_out;
    logic [STAGES-1:0] stage_en;

    int errors = 0;
    int checks = 0;
    bit primed = 1'b0;
    bit finished = 1'b0;

    // reference model state
    bit          m_mode = 1'b0;
    int          m_i = 0;
    int          m_q = 0;
    bit          exp_en[$];
    bit          fresh = 1'b0;
    string       tag_d = "R1";
    string       tag_e = "R1";

    sample_gate_ctrl #(.DATA_W(DATA_W), .STAGES(STAGES)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_interp (cfg_interp),
        .in_en_n    (in_en_n),
        .i_in       (i_in),
        .q_in       (q_in),
        .i_out      (i_out),
        .q_out      (q_out),
        .stage_en   (stage_en)
    );

    always #2.5 clk = ~clk;

    initial begin
        for (int k = 0; k < STAGES; k++) exp_en.push_back(1'b0);
    end

    // Reference model: advance on every rising edge from the sampled inputs.
    always @(posedge clk) begin
        bit acc;
        if (!rst_n) begin
            m_mode = 1'b0;
            m_i = 0;
            m_q = 0;
            foreach (exp_en[k]) exp_en[k] = 1'b0;
            fresh = 1'b0;
            tag_d = "R1";
            tag_e = "R1";
        end else begin
            acc = m_mode ? 1'b1 : !in_en_n;
            if (!in_en_n) begin
                m_i = int'(i_in);
                m_q = int'(q_in);
            end else if (m_mode) begin
                m_i = 0;
                m_q = 0;
            end
            tag_d = m_mode ? (!in_en_n ? "R7" : "R8") : (!in_en_n ? "R2" : "R3");
            tag_e = fresh ? "R6" : (m_mode ? "R9" : "R4");
            exp_en.push_front(acc);
            void'(exp_en.pop_back());
            fresh = cfg_wr;
            if (cfg_wr) m_mode = cfg_interp;
        end
        primed = 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (primed && !finished) begin
            chk({tag_d, " i_out"}, int'(i_out), m_i);
            chk({tag_d, " q_out"}, int'(q_out), m_q);
            chk({tag_e, " stage_en[0]"}, int'(stage_en[0]), int'(exp_en[0]));
            for (int k = 1; k < STAGES; k++)
                chk((tag_d == "R1") ? "R1 stage_en" : "R5 stage_en",
                    int'(stage_en[k]), int'(exp_en[k]));
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic cyc(input bit en_n, input bit wr, input bit val);
        @(negedge clk);
        in_en_n    = en_n;
        cfg_wr     = wr;
        cfg_interp = val;
        i_in       = DATA_W'($urandom);
        q_in       = DATA_W'($urandom);
    endtask

    initial begin
        // R1: reset from time zero
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // R2 R3 R4 R5: gated, random enable
        for (int n = 0; n < 60; n++) cyc(1'($urandom), 1'b0, 1'b0);
        // R2 R3: gated, one sample in three
        for (int n = 0; n < 30; n++) cyc((n % 3) != 0, 1'b0, 1'b0);
        // R6: switch to interpolated
        cyc(1'b1, 1'b1, 1'b1);
        // R7 R8 R9: interpolated, random enable
        for (int n = 0; n < 60; n++) cyc(1'($urandom), 1'b0, 1'b0);
        // R8: enable idle, zero stuffing
        for (int n = 0; n < 10; n++) cyc(1'b1, 1'b0, 1'b0);
        // R6: back to gated with enable idle, chain drains
        cyc(1'b1, 1'b1, 1'b0);
        for (int n = 0; n < 10; n++) cyc(1'b1, 1'b0, 1'b0);
        // R1: reset in the middle of interpolated operation
        cyc(1'b0, 1'b1, 1'b1);
        for (int n = 0; n < 5; n++) cyc(1'($urandom), 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) cyc(1'b0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        for (int n = 0; n < 10; n++) cyc(1'($urandom), 1'b0, 1'b0);
        // mixed run with occasional mode writes
        for (int n = 0; n < 2000; n++)
            cyc(1'($urandom), ($urandom % 16) == 0, 1'($urandom));
        cyc(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

endmodule